// File: doc/BRIEF.md
# Flash Sector Access Protection Checker

This block stands between a bus master and a flash array controller and rules on every read, program and erase request before it reaches the array. It turns the request address into a 4 KB sector number and then into a protection cluster of four adjacent sectors. It applies one write-protect bit per cluster and a single read lock that covers the whole flash. It also rejects program requests that do not start on a 128-byte block and reads that do not start on a 16-byte line. Program and erase requests to the sector that holds the internal parameters are always refused.

A two-word password, written in order through a small unlock port, lifts the cluster write protection and the read lock until the master sends a relock command or the block is reset. A wrong word drops the sequence and sets a sticky violation flag. The protection settings come in on configuration inputs and are captured while reset is held. A granted request is passed to the array controller in the same cycle. A refused request is never passed on and raises an error pulse in that cycle instead.

Top module: `flash_guard`

## Requirements
- R1: The sector index is address bits [ADDR_W-1:12] and the cluster index is the sector index shifted right by two. While locked, a program or erase to a sector whose cluster has its write-protect bit set is denied.
- R2: A program request whose address bits [6:0] are not all zero is denied, whether the block is locked or unlocked.
- R3: A read request whose address bits [3:0] are not all zero is denied, whether the block is locked or unlocked.
- R4: While the captured read lock is set and the block is locked, every read request is denied.
- R5: A password write of PWD0 followed by a password write of PWD1 (the writes need not be in adjacent cycles) sets the unlocked state from the next cycle. While unlocked, the cluster write protection (R1) and the read lock (R4) do not apply.
- R6: A password write whose word is not the one expected at that step returns the sequence to its start and sets the violation flag. The flag stays set until reset.
- R7: An asserted relock input ends the unlocked state and any partial sequence from the next cycle, and it overrides a password write in the same cycle. Reset also ends the unlocked state.
- R8: A program or erase to parameter sector PARAM_SECTOR (default 15, addresses 0xF000 to 0xFFFF) is always denied, even while unlocked. Reads to that sector follow R3 and R4.
- R9: Operation codes are 00 read, 01 program, 10 erase and 11 invalid, which is always denied. A granted request drives fwd_valid_o with the same op and address in its own cycle. A denied request raises deny_err_o in its own cycle and leaves fwd_valid_o low.
- R10: The write-protect mask and the read lock are sampled while rst_i is high. Later changes on those inputs have no effect until the next reset.
- R11: A request is judged on the unlock state held before any password write or relock in the same cycle takes effect.
- R12: Password writes made while unlocked are ignored: they do not change the unlocked state or the violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; captures the configuration |
| wp_cfg_i | input | NUM_CLUSTERS | Write-protect bit per cluster, sampled during reset |
| rd_lock_cfg_i | input | 1 | Global read lock, sampled during reset |
| req_valid_i | input | 1 | Request strobe from the master |
| req_op_i | input | 2 | Operation code (R9) |
| req_addr_i | input | ADDR_W | Byte address of the request |
| pw_valid_i | input | 1 | Password word write strobe |
| pw_data_i | input | 32 | Password word |
| relock_i | input | 1 | Ends the unlocked state |
| fwd_valid_o | output | 1 | Granted request toward the array controller |
| fwd_op_o | output | 2 | Forwarded operation code |
| fwd_addr_o | output | ADDR_W | Forwarded address |
| deny_err_o | output | 1 | One-cycle error for a denied request |
| unlocked_o | output | 1 | Password unlock in force |
| pw_violation_o | output | 1 | Sticky wrong-password flag |

## Verification
The outcome of a request and an unlock-state change can land in the same cycle. The bench provokes this by putting a read to a locked area in the same cycle as the closing password word, and by putting a read in the same cycle as a relock together with a password write. Under R11 the first read must be denied and the second granted, because both are judged on the old state. The bench then checks unlocked_o and a repeated read one cycle later to confirm that the new state has taken effect.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_BAD   = 2'b11
    } fg_op_e;

    typedef enum logic [1:0] {
        PW_IDLE = 2'b00,
        PW_HALF = 2'b01,
        PW_OPEN = 2'b10
    } fg_pw_state_e;

    typedef struct packed {
        fg_pw_state_e st;
        logic         viol;
    } fg_unlock_s;

endpackage

// File: rtl/fg_addr_map.sv
module fg_addr_map #(
    parameter int ADDR_W       = 20,
    parameter int SECT_SHIFT   = 12,
    parameter int CLU_LOG2     = 2,
    parameter int PROG_LOG2    = 7,
    parameter int READ_LOG2    = 4,
    parameter int PARAM_SECTOR = 15,
    localparam int SECT_W      = ADDR_W - SECT_SHIFT,
    localparam int CLU_W       = SECT_W - CLU_LOG2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SECT_W-1:0] sector_o,
    output logic [CLU_W-1:0]  cluster_o,
    output logic              is_param_o,
    output logic              prog_aligned_o,
    output logic              read_aligned_o
);

    always_comb begin
        sector_o       = addr_i[ADDR_W-1:SECT_SHIFT];
        cluster_o      = sector_o[SECT_W-1:CLU_LOG2];
        is_param_o     = (sector_o == SECT_W'(PARAM_SECTOR));
        prog_aligned_o = (addr_i[PROG_LOG2-1:0] == '0);
        read_aligned_o = (addr_i[READ_LOG2-1:0] == '0);
    end

endmodule

// File: rtl/fg_unlock_fsm.sv
module fg_unlock_fsm
    import flash_guard_pkg::*;
#(
    parameter logic [31:0] PWD0 = 32'hA5C3_1E7F,
    parameter logic [31:0] PWD1 = 32'h5A3C_E180
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        pw_valid_i,
    input  logic [31:0] pw_data_i,
    input  logic        relock_i,
    output logic        unlocked_o,
    output logic        violation_o
);

    fg_unlock_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (relock_i) begin
            st_d.st = PW_IDLE;
        end else if (pw_valid_i) begin
            unique case (st_q.st)
                PW_IDLE: begin
                    if (pw_data_i == PWD0) begin
                        st_d.st = PW_HALF;
                    end else begin
                        st_d.viol = 1'b1;
                    end
                end
                PW_HALF: begin
                    if (pw_data_i == PWD1) begin
                        st_d.st = PW_OPEN;
                    end else begin
                        st_d.st   = PW_IDLE;
                        st_d.viol = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (rst_i) begin
            st_d.st   = PW_IDLE;
            st_d.viol = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign unlocked_o  = (st_q.st == PW_OPEN);
    assign violation_o = st_q.viol;

endmodule

// File: rtl/fg_decide.sv
module fg_decide
    import flash_guard_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] op_i,
    input  logic       is_param_i,
    input  logic       prog_aligned_i,
    input  logic       read_aligned_i,
    input  logic       wp_bit_i,
    input  logic       rd_lock_i,
    input  logic       unlocked_i,
    output logic       grant_o,
    output logic       deny_o
);

    logic ok;

    always_comb begin
        unique case (fg_op_e'(op_i))
            OP_READ:  ok = read_aligned_i && (!rd_lock_i || unlocked_i);
            OP_PROG:  ok = prog_aligned_i && !is_param_i && (!wp_bit_i || unlocked_i);
            OP_ERASE: ok = !is_param_i && (!wp_bit_i || unlocked_i);
            default:  ok = 1'b0;
        endcase
        grant_o = valid_i && ok;
        deny_o  = valid_i && !ok;
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int          ADDR_W       = 20,
    parameter int          SECT_SHIFT   = 12,
    parameter int          CLU_LOG2     = 2,
    parameter int          PARAM_SECTOR = 15,
    parameter logic [31:0] PWD0         = 32'hA5C3_1E7F,
    parameter logic [31:0] PWD1         = 32'h5A3C_E180,
    localparam int         SECT_W       = ADDR_W - SECT_SHIFT,
    localparam int         CLU_W        = SECT_W - CLU_LOG2,
    localparam int         NUM_CLUSTERS = 1 << CLU_W
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [NUM_CLUSTERS-1:0] wp_cfg_i,
    input  logic                    rd_lock_cfg_i,
    input  logic                    req_valid_i,
    input  logic [1:0]              req_op_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic                    pw_valid_i,
    input  logic [31:0]             pw_data_i,
    input  logic                    relock_i,
    output logic                    fwd_valid_o,
    output logic [1:0]              fwd_op_o,
    output logic [ADDR_W-1:0]       fwd_addr_o,
    output logic                    deny_err_o,
    output logic                    unlocked_o,
    output logic                    pw_violation_o
);

    typedef struct packed {
        logic [NUM_CLUSTERS-1:0] wp;
        logic                    rd_lock;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rst_i) begin
            cfg_d.wp      = wp_cfg_i;
            cfg_d.rd_lock = rd_lock_cfg_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    logic              rd_lock_q;
    logic [SECT_W-1:0] sector;
    logic [CLU_W-1:0]  cluster;
    logic              is_param, prog_aligned, read_aligned, grant;

    assign rd_lock_q = cfg_q.rd_lock;

    fg_addr_map #(
        .ADDR_W       (ADDR_W),
        .SECT_SHIFT   (SECT_SHIFT),
        .CLU_LOG2     (CLU_LOG2),
        .PROG_LOG2    (7),
        .READ_LOG2    (4),
        .PARAM_SECTOR (PARAM_SECTOR)
    ) u_map (
        .addr_i         (req_addr_i),
        .sector_o       (sector),
        .cluster_o      (cluster),
        .is_param_o     (is_param),
        .prog_aligned_o (prog_aligned),
        .read_aligned_o (read_aligned)
    );

    fg_unlock_fsm #(
        .PWD0 (PWD0),
        .PWD1 (PWD1)
    ) u_unlock (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pw_valid_i  (pw_valid_i),
        .pw_data_i   (pw_data_i),
        .relock_i    (relock_i),
        .unlocked_o  (unlocked_o),
        .violation_o (pw_violation_o)
    );

    fg_decide u_decide (
        .valid_i        (req_valid_i),
        .op_i           (req_op_i),
        .is_param_i     (is_param),
        .prog_aligned_i (prog_aligned),
        .read_aligned_i (read_aligned),
        .wp_bit_i       (cfg_q.wp[cluster]),
        .rd_lock_i      (cfg_q.rd_lock),
        .unlocked_i     (unlocked_o),
        .grant_o        (grant),
        .deny_o         (deny_err_o)
    );

    assign fwd_valid_o = grant;
    assign fwd_op_o    = req_op_i;
    assign fwd_addr_o  = req_addr_i;

endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
    parameter int          ADDR_W       = 20,
    parameter int          SECT_SHIFT   = 12,
    parameter int          PARAM_SECTOR = 15,
    parameter logic [31:0] PWD1         = 32'h5A3C_E180
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              req_valid_i,
    input logic              fwd_valid_o,
    input logic [1:0]        fwd_op_o,
    input logic [ADDR_W-1:0] fwd_addr_o,
    input logic              deny_err_o,
    input logic              pw_valid_i,
    input logic [31:0]       pw_data_i,
    input logic              relock_i,
    input logic              unlocked_o,
    input logic              pw_violation_o,
    input logic              rd_lock_q
);

    assert_one_outcome_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i |-> (fwd_valid_o ^ deny_err_o));

    assert_quiet_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |-> (!fwd_valid_o && !deny_err_o));

    assert_prog_align_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (fwd_valid_o && fwd_op_o == 2'b01) |-> (fwd_addr_o[6:0] == 7'd0));

    assert_read_align_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (fwd_valid_o && fwd_op_o == 2'b00) |-> (fwd_addr_o[3:0] == 4'd0));

    assert_read_lock_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (fwd_valid_o && fwd_op_o == 2'b00) |-> (!rd_lock_q || unlocked_o));

    assert_param_sector_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (fwd_valid_o && fwd_op_o != 2'b00)
            |-> (fwd_addr_o[ADDR_W-1:SECT_SHIFT] != (ADDR_W-SECT_SHIFT)'(PARAM_SECTOR)));

    assert_unlock_source_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(unlocked_o) |-> $past(pw_valid_i && pw_data_i == PWD1 && !relock_i));

    assert_sticky_violation_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(pw_violation_o) |-> pw_violation_o);

    assert_relock_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        relock_i |=> !unlocked_o);

endmodule

bind flash_guard fg_checker #(
    .ADDR_W       (ADDR_W),
    .SECT_SHIFT   (SECT_SHIFT),
    .PARAM_SECTOR (PARAM_SECTOR),
    .PWD1         (PWD1)
) u_fg_checker (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .req_valid_i    (req_valid_i),
    .fwd_valid_o    (fwd_valid_o),
    .fwd_op_o       (fwd_op_o),
    .fwd_addr_o     (fwd_addr_o),
    .deny_err_o     (deny_err_o),
    .pw_valid_i     (pw_valid_i),
    .pw_data_i      (pw_data_i),
    .relock_i       (relock_i),
    .unlocked_o     (unlocked_o),
    .pw_violation_o (pw_violation_o),
    .rd_lock_q      (rd_lock_q)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 20;
    localparam int          NCLU       = 64;
    localparam logic [31:0] KEY_A      = 32'h1357_9BDF;
    localparam logic [31:0] KEY_B      = 32'h2468_ACE0;
    localparam logic [1:0]  RD = 2'b00, PG = 2'b01, ER = 2'b10, BAD = 2'b11;

    logic              clk = 1'b0;
    logic              rst_i = 1'b1;
    logic [NCLU-1:0]   wp_cfg_i = '0;
    logic              rd_lock_cfg_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic [1:0]        req_op_i = 2'b00;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic              pw_valid_i = 1'b0;
    logic [31:0]       pw_data_i = '0;
    logic              relock_i = 1'b0;
    logic              fwd_valid_o, deny_err_o, unlocked_o, pw_violation_o;
    logic [1:0]        fwd_op_o;
    logic [ADDR_W-1:0] fwd_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard #(
        .ADDR_W (ADDR_W),
        .PWD0   (KEY_A),
        .PWD1   (KEY_B)
    ) uut (
        .clk_i          (clk),
        .rst_i          (rst_i),
        .wp_cfg_i       (wp_cfg_i),
        .rd_lock_cfg_i  (rd_lock_cfg_i),
        .req_valid_i    (req_valid_i),
        .req_op_i       (req_op_i),
        .req_addr_i     (req_addr_i),
        .pw_valid_i     (pw_valid_i),
        .pw_data_i      (pw_data_i),
        .relock_i       (relock_i),
        .fwd_valid_o    (fwd_valid_o),
        .fwd_op_o       (fwd_op_o),
        .fwd_addr_o     (fwd_addr_o),
        .deny_err_o     (deny_err_o),
        .unlocked_o     (unlocked_o),
        .pw_violation_o (pw_violation_o)
    );

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One request in one cycle; outcome sampled 1 time unit after the falling edge.
    task automatic do_req(logic [1:0] op, logic [ADDR_W-1:0] a, bit exp_g, string tag);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_op_i    = op;
        req_addr_i  = a;
        #1;
        check_eq({tag, " grant"}, fwd_valid_o, exp_g);
        check_eq({tag, " error"}, deny_err_o, !exp_g);
        if (exp_g) begin
            check_eq({tag, " fwd addr"}, fwd_addr_o, a);
            check_eq({tag, " fwd op"}, fwd_op_o, op);
        end
        @(posedge clk);
        #1;
        req_valid_i = 1'b0;
    endtask

    task automatic pw_write(logic [31:0] w);
        @(negedge clk);
        pw_valid_i = 1'b1;
        pw_data_i  = w;
        @(posedge clk);
        #1;
        pw_valid_i = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
    endtask

    task automatic t_reset_state();
        #1;
        check_eq("R9 reset fwd_valid", fwd_valid_o, 0);
        check_eq("R9 reset deny_err", deny_err_o, 0);
        check_eq("R7 reset unlocked", unlocked_o, 0);
        check_eq("R6 reset violation", pw_violation_o, 0);
    endtask

    task automatic t_locked_rules();
        do_req(RD, 20'h00100, 0, "R4 locked read");
        do_req(PG, 20'h04000, 0, "R1 prog protected cluster 1");
        do_req(ER, 20'h07FF0, 0, "R1 erase sector 7 cluster 1");
        do_req(PG, 20'h00080, 1, "R1 prog open cluster 0");
        do_req(ER, 20'h08000, 1, "R1 erase open cluster 2");
        do_req(PG, 20'h00040, 0, "R2 misaligned program");
        do_req(PG, 20'h0F000, 0, "R8 prog parameter sector");
        do_req(ER, 20'h0F800, 0, "R8 erase parameter sector");
        do_req(PG, 20'h0E000, 1, "R8 prog sector below parameter");
        do_req(BAD, 20'h00000, 0, "R9 invalid op");
    endtask

    task automatic t_cfg_frozen();
        @(negedge clk);
        wp_cfg_i      = '0;
        rd_lock_cfg_i = 1'b0;
        do_req(PG, 20'h04000, 0, "R10 wp change after reset");
        do_req(RD, 20'h00200, 0, "R10 read lock change after reset");
    endtask

    task automatic t_unlock_same_cycle();
        pw_write(KEY_A);
        check_eq("R5 half sequence still locked", unlocked_o, 0);
        @(negedge clk);
        pw_valid_i  = 1'b1;
        pw_data_i   = KEY_B;
        req_valid_i = 1'b1;
        req_op_i    = RD;
        req_addr_i  = 20'h00100;
        #1;
        check_eq("R11 read with closing word denied", deny_err_o, 1);
        check_eq("R11 read with closing word not forwarded", fwd_valid_o, 0);
        @(posedge clk);
        #1;
        pw_valid_i  = 1'b0;
        req_valid_i = 1'b0;
        check_eq("R5 unlocked after sequence", unlocked_o, 1);
        check_eq("R6 no violation on good sequence", pw_violation_o, 0);
        do_req(RD, 20'h00100, 1, "R5 read unlocked");
        do_req(RD, 20'h00108, 0, "R3 misaligned read unlocked");
        do_req(PG, 20'h04000, 1, "R5 prog protected cluster unlocked");
        do_req(PG, 20'h04010, 0, "R2 misaligned program unlocked");
        do_req(PG, 20'h0F000, 0, "R8 prog parameter sector unlocked");
        do_req(ER, 20'h0F000, 0, "R8 erase parameter sector unlocked");
        do_req(RD, 20'h0F000, 1, "R8 read parameter sector unlocked");
    endtask

    task automatic t_ignored_while_open();
        pw_write(32'hDEAD_BEEF);
        check_eq("R12 wrong word while unlocked keeps unlock", unlocked_o, 1);
        check_eq("R12 wrong word while unlocked no violation", pw_violation_o, 0);
    endtask

    task automatic t_relock();
        @(negedge clk);
        relock_i    = 1'b1;
        pw_valid_i  = 1'b1;
        pw_data_i   = KEY_A;
        req_valid_i = 1'b1;
        req_op_i    = RD;
        req_addr_i  = 20'h00300;
        #1;
        check_eq("R11 read in relock cycle granted", fwd_valid_o, 1);
        @(posedge clk);
        #1;
        relock_i    = 1'b0;
        pw_valid_i  = 1'b0;
        req_valid_i = 1'b0;
        check_eq("R7 relock ends unlock", unlocked_o, 0);
        do_req(RD, 20'h00300, 0, "R7 read after relock");
        // Relock beat the password write: KEY_B alone is now a wrong first word.
        pw_write(KEY_B);
        check_eq("R7 relock dropped the word", unlocked_o, 0);
        check_eq("R6 wrong first word flags", pw_violation_o, 1);
    endtask

    task automatic t_wrong_sequence();
        pw_write(KEY_A);
        pw_write(KEY_A);
        check_eq("R6 wrong second word stays locked", unlocked_o, 0);
        pw_write(KEY_B);
        check_eq("R6 sequence restarted", unlocked_o, 0);
        pw_write(KEY_A);
        pw_write(KEY_B);
        check_eq("R5 unlock after violations", unlocked_o, 1);
        check_eq("R6 violation sticky", pw_violation_o, 1);
        apply_reset();
        #1;
        check_eq("R7 reset ends unlock", unlocked_o, 0);
        check_eq("R6 reset clears violation", pw_violation_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Cluster 1 (sectors 4..7) write-protected, read lock on.
        wp_cfg_i      = NCLU'(64'h2);
        rd_lock_cfg_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        t_reset_state();
        t_locked_rules();
        t_cfg_frozen();
        t_unlock_same_cycle();
        t_ignored_while_open();
        t_relock();
        t_wrong_sequence();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule